// File: doc/BRIEF.md
# I2C Bus Line Conditioner with Arbitration Detection

This block sits between the SCL and SDA pads of an I2C master and the master's bit-level sequencer. Each raw line is sampled on a clock enable that the sequencer issues at four times its own bit tick. The samples go through a majority (median) filter, so a glitch that lasts one sample never reaches the filtered line. Slow bus edges that bounce while they cross the threshold are smoothed out the same way.

The block watches the filtered lines on every system clock. It reports START and STOP conditions as one-cycle pulses and keeps a bus-busy flag. It raises a one-cycle arbitration-lost pulse in two cases. The first is when the master has released SDA but the filtered SDA reads low at the sequencer's check strobe. The second is when a STOP the master did not ask for shows up while the master is idle. An unrequested STOP seen while the master is in any other state is reported on the stop output only. A noisy line therefore cannot abort a transfer that is under way.

Top module: `i2c_line_cond`

## Requirements
- R1: After reset the filtered SCL and SDA outputs are 1, and start, stop, busy and arbitration-lost are 0.
- R2: A raw level that is present in only one sample of a three-sample window never changes a filtered output, on either line.
- R3: When a raw line holds a new level for two consecutive enabled samples, the filtered output takes that level in the clock cycle right after the second enabled sample.
- R4: While the sample enable is low, changes on the raw lines do not change the filtered outputs.
- R5: A falling edge of filtered SDA while filtered SCL is 1 gives a one-cycle start pulse in the same cycle, and busy reads 1 from the next cycle on.
- R6: A rising edge of filtered SDA while filtered SCL is 1 gives a one-cycle stop pulse in the same cycle, and busy reads 0 from the next cycle on.
- R7: An edge of filtered SDA while filtered SCL is 0 gives neither a start nor a stop pulse.
- R8: If the check strobe is 1 while the SDA release input is 1 and filtered SDA is 0, arbitration-lost is 1 for exactly one cycle, the cycle after the strobe. If SDA release is 0, or filtered SDA is 1, there is no pulse.
- R9: A stop pulse while the idle input is 1 and the stop-requested input is 0 makes arbitration-lost 1 for the one cycle after the stop pulse.
- R10: A stop pulse while the idle input is 0, or while stop-requested is 1, does not raise arbitration-lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| smp_en | input | 1 | Filter sample enable, four pulses per bit tick |
| scl_raw | input | 1 | SCL level from the pad |
| sda_raw | input | 1 | SDA level from the pad |
| sda_rel | input | 1 | 1 when the master releases SDA (drives it high) |
| chk_stb | input | 1 | SDA check strobe from the sequencer |
| stop_req | input | 1 | 1 when the master has asked for a STOP |
| idle | input | 1 | 1 when the master sequencer is idle |
| scl_f | output | 1 | Filtered SCL |
| sda_f | output | 1 | Filtered SDA |
| start_p | output | 1 | START detected, one-cycle pulse |
| stop_p | output | 1 | STOP detected, one-cycle pulse |
| busy | output | 1 | Bus is between a START and a STOP |
| arb_lost | output | 1 | Arbitration lost, one-cycle pulse |

## Verification
The filter and the event detector are driven by a table of line pairs, one enabled sample per row. The rows cover a clean START, SDA edges while SCL is low, a one-sample SCL pulse, a one-sample SDA dip while SCL is high, and a STOP. These rows separate a correct majority vote from a filter that passes raw samples straight through, and they separate the SCL-high qualification of start and stop from edge detection alone. Directed sequences then toggle the raw lines with the enable held low. They also hit the check strobe under each combination of SDA release and filtered level, and produce STOPs under each combination of idle and stop-requested. This shows which sources may raise arbitration-lost.

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic scl_raw,
  input  logic sda_raw,
  input  logic sda_rel,
  input  logic chk_stb,
  input  logic stop_req,
  input  logic idle,
  output logic scl_f,
  output logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic busy,
  output logic arb_lost
);

  localparam int HALF = TAPS / 2;

  logic [TAPS-1:0] scl_h, sda_h;
  logic            sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_h <= '1;
      sda_h <= '1;
    end else if (smp_en) begin
      scl_h <= {scl_h[TAPS-2:0], scl_raw};
      sda_h <= {sda_h[TAPS-2:0], sda_raw};
    end
  end

  assign scl_f = $countones(scl_h) > HALF;
  assign sda_f = $countones(sda_h) > HALF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_q <= 1'b1;
    else        sda_q <= sda_f;
  end

  assign start_p = scl_f &  sda_q & ~sda_f;
  assign stop_p  = scl_f & ~sda_q &  sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy <= 1'b0;
    else if (start_p) busy <= 1'b1;
    else if (stop_p)  busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arb_lost <= 1'b0;
    else        arb_lost <= (chk_stb & sda_rel & ~sda_f) |
                            (stop_p & ~stop_req & idle);
  end

  assert_filt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_f) || !$stable(scl_f) |-> $past(smp_en));

  assert_busy_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> busy);

  assert_busy_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !busy);

  assert_stop_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_f |-> !start_p && !stop_p);

  assert_arb_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> $past(chk_stb) || $past(stop_p));

  assert_arb_rel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_stb && !sda_rel && !stop_p |=> !arb_lost);

  assert_idle_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p && idle && !stop_req |=> arb_lost);

  assert_busy_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p && (!idle || stop_req) && !chk_stb |=> !arb_lost);

endmodule

// File: tb/i2c_line_cond_bench.sv
`timescale 1ns/1ps
module i2c_line_cond_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_en = 1'b0, scl_raw = 1'b1, sda_raw = 1'b1;
  logic sda_rel = 1'b0, chk_stb = 1'b0, stop_req = 1'b0, idle = 1'b0;
  logic scl_f, sda_f, start_p, stop_p, busy, arb_lost;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_line_cond u_i2c_line_cond (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .scl_raw(scl_raw),
    .sda_raw(sda_raw), .sda_rel(sda_rel), .chk_stb(chk_stb),
    .stop_req(stop_req), .idle(idle), .scl_f(scl_f), .sda_f(sda_f),
    .start_p(start_p), .stop_p(stop_p), .busy(busy), .arb_lost(arb_lost)
  );

  // {scl_raw, sda_raw, scl_f, sda_f, start_p, stop_p, busy}
  localparam int NV = 17;
  localparam logic [6:0] VEC [NV] = '{
    7'b11_11_000, 7'b10_11_000, 7'b10_10_101, 7'b00_10_001,
    7'b00_00_001, 7'b01_00_001, 7'b01_01_001, 7'b00_01_001,
    7'b00_00_001, 7'b10_00_001, 7'b00_00_001, 7'b10_10_001,
    7'b11_10_001, 7'b11_11_010, 7'b10_11_000, 7'b11_11_000,
    7'b11_11_000
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample(input logic s, input logic d);
    scl_raw = s; sda_raw = d; smp_en = 1'b1;
    @(posedge clk); @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic settle(input logic s, input logic d);
    for (int k = 0; k < 3; k++) sample(s, d);
  endtask

  task automatic strobe(input logic rel);
    sda_rel = rel; chk_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_stb = 1'b0; sda_rel = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 scl_f", scl_f, 1'b1);
    chk("R1 sda_f", sda_f, 1'b1);
    chk("R1 start", start_p, 1'b0);
    chk("R1 stop", stop_p, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 arb", arb_lost, 1'b0);

    for (int i = 0; i < NV; i++) begin
      sample(VEC[i][6], VEC[i][5]);
      chk("R2 R3 scl_f", scl_f, VEC[i][4]);
      chk("R2 R3 sda_f", sda_f, VEC[i][3]);
      chk("R5 R7 start", start_p, VEC[i][2]);
      chk("R6 R7 stop", stop_p, VEC[i][1]);
      @(posedge clk); @(negedge clk);
      chk("R5 R6 busy", busy, VEC[i][0]);
      chk("R10 arb", arb_lost, 1'b0);
    end

    scl_raw = 1'b0; sda_raw = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      scl_raw = ~scl_raw;
    end
    chk("R4 scl_f", scl_f, 1'b1);
    chk("R4 sda_f", sda_f, 1'b1);
    chk("R4 start", start_p, 1'b0);

    settle(0, 1);
    settle(0, 0);
    chk("R7 busy", busy, 1'b0);
    strobe(1'b1);
    chk("R8 arb on", arb_lost, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R8 arb single", arb_lost, 1'b0);
    strobe(1'b0);
    chk("R8 arb not released", arb_lost, 1'b0);
    settle(0, 1);
    strobe(1'b1);
    chk("R8 arb sda high", arb_lost, 1'b0);

    idle = 1'b1; stop_req = 1'b0;
    settle(0, 0); settle(1, 0);
    sample(1, 1); sample(1, 1);
    chk("R9 stop", stop_p, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 arb", arb_lost, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R9 arb single", arb_lost, 1'b0);

    stop_req = 1'b1;
    settle(0, 1); settle(0, 0); settle(1, 0);
    sample(1, 1); sample(1, 1);
    chk("R10 stop", stop_p, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R10 arb requested", arb_lost, 1'b0);

    idle = 1'b0; stop_req = 1'b0;
    settle(0, 1); settle(0, 0); settle(1, 0);
    sample(1, 1); sample(1, 1);
    chk("R10 stop busy", stop_p, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R10 arb not idle", arb_lost, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule